// File: doc/BRIEF.md
# Sound Log Command Stream Decoder

This block turns a recorded stream of sound-chip commands into timed register writes. Bytes arrive one per cycle on a valid/ready handshake. Each opcode is classified by its range, and its operands are gathered least significant byte first. A register or port write leaves on a one-cycle strobe with four fields: a target (the opcode itself), a port, an address and a data byte. A bank seek leaves on its own strobe with a 32-bit offset.

Wait commands load a sample counter. That counter falls by one on each pulse of an external sample-rate tick, and input ready stays low until it reaches zero. Embedded data blocks are stepped over using their in-stream 32-bit little-endian length. Reserved opcodes are stepped over by the operand count of their range. The end-of-stream opcode parks the block until reset.

The controller has six states. IDLE_OP waits for an opcode. GATHER collects operands. ISSUE is a one-cycle step that raises strobes and loads the counters. HOLD counts sample ticks. DRAIN swallows block payload. HALT is reached after end of stream.

Transitions:
- IDLE_OP goes to GATHER when an opcode with operands is accepted, or to ISSUE when an opcode without operands is accepted.
- GATHER goes to ISSUE on its last operand.
- ISSUE goes to HALT for end of stream, to HOLD for a non-zero wait, to DRAIN for a non-empty block, and to IDLE_OP otherwise.
- HOLD goes to IDLE_OP on the tick that brings the count from one to zero.
- DRAIN goes to IDLE_OP on the last payload byte.

Top module: `slog_decoder`

## Requirements
- R1: A synchronous reset puts the block in IDLE_OP, where in_ready=1, done=0 and neither strobe is high. The next accepted byte is treated as an opcode.
- R2: Opcodes 0x4f and 0x50 take one operand. They produce a write with wr_target equal to the opcode, wr_port=0, wr_addr=0 and wr_data equal to the operand.
- R3: Opcodes 0x51 to 0x5f and opcode 0xb0 take an address byte and then a data byte. They produce a write with wr_port=0, wr_addr equal to the address byte (zero-extended) and wr_data equal to the data byte.
- R4: Opcodes 0xc0 and 0xc1 take a 16-bit address, low byte first, and then a data byte. Opcodes 0xd0 and 0xd1 take a port, an address and a data byte, in that order. The write fields carry these values.
- R5: wr_valid is high for exactly one cycle per write command. That cycle is the one right after the final operand is accepted, and in_ready is low during it.
- R6: Opcode 0x61 takes a 16-bit count, low byte first, and holds input for that many ticks. A count of zero releases input without any tick.
- R7: Opcode 0x62 holds for 735 ticks and opcode 0x63 holds for 882 ticks. Opcodes 0x70 to 0x7f hold for (low nibble + 1) ticks.
- R8: Opcodes 0x80 to 0x8f raise one write with wr_target equal to the opcode and port, address and data all zero. They then hold for exactly (low nibble) ticks.
- R9: While a hold is pending, in_ready=0. The remaining count drops by one only on cycles where tick=1.
- R10: Opcode 0xe0 takes four bytes, low byte first, and raises seek_valid for one cycle with seek_offset equal to that value.
- R11: A data block is 0x67, a marker byte, a type byte, a 4-byte size (low byte first), and then that many payload bytes. The whole block is consumed with no strobe, whatever its type, and a size of zero is allowed.
- R12: Reserved opcodes are consumed with no strobe, using these operand counts: 0x30 to 0x4e take 1; 0xa0 to 0xaf and 0xb1 to 0xbf take 2; 0xc2 to 0xcf and 0xd2 to 0xdf take 3; 0xe1 to 0xff take 4.
- R13: Opcode 0x66 raises done. After that, done stays high and in_ready stays low until reset.
- R14: All other opcodes (0x00 to 0x2f, 0x60, 0x64, 0x65, 0x68 to 0x6f and 0x90 to 0x9f) are single bytes with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts the byte this cycle |
| tick | input | 1 | One pulse per output sample |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_target | output | 8 | Opcode that selects the target chip/port |
| wr_port | output | 8 | Port operand (0xd0/0xd1), else 0 |
| wr_addr | output | 16 | Register or memory address |
| wr_data | output | 8 | Data byte |
| seek_valid | output | 1 | One-cycle bank seek strobe |
| seek_offset | output | 32 | Bank seek offset |
| done | output | 1 | End of stream reached |

## Verification
A wrong operand count does not stay local. The stream loses framing, so the very next operand byte of 0x50 is decoded as a write, and the scoreboard flags it as unexpected within one command. A hold count that is off by one shows up at in_ready. Ready either rises before the last tick, or is still low one tick after it; the bench checks both points exactly. A payload counter fault either swallows the write that follows the block or turns payload bytes into strobes. Both are visible within a few cycles of the block's end.

// File: rtl/slog_pkg.sv
package slog_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAX_OPS = 6;
    localparam int NOPS_W  = $clog2(MAX_OPS + 1);
    localparam int WAIT_W  = 2 * BYTE_W;
    localparam int ADDR_W  = 2 * BYTE_W;
    localparam int LEN_W   = 4 * BYTE_W;
    localparam int SEEK_W  = 4 * BYTE_W;

    localparam logic [WAIT_W-1:0] HOLD_SIXTIETH = WAIT_W'(735);
    localparam logic [WAIT_W-1:0] HOLD_FIFTIETH = WAIT_W'(882);

    typedef enum logic [3:0] {
        K_IGNORE,
        K_WRITE,
        K_WAIT_ARG,
        K_WAIT_FIX,
        K_BANK,
        K_END,
        K_BLOCK,
        K_SEEK,
        K_SKIP
    } op_kind_e;

    typedef enum logic [2:0] {
        IDLE_OP,
        GATHER,
        ISSUE,
        HOLD,
        DRAIN,
        HALT
    } dec_state_e;

endpackage

// File: rtl/slog_op_classify.sv
module slog_op_classify
    import slog_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output op_kind_e          kind,
    output logic [NOPS_W-1:0] nops,
    output logic [WAIT_W-1:0] fix_wait
);

    always_comb begin
        kind     = K_IGNORE;
        nops     = '0;
        fix_wait = '0;
        unique case (op) inside
            [8'h30:8'h4e]: begin
                kind = K_SKIP;
                nops = NOPS_W'(1);
            end
            8'h4f, 8'h50: begin
                kind = K_WRITE;
                nops = NOPS_W'(1);
            end
            [8'h51:8'h5f], 8'hb0: begin
                kind = K_WRITE;
                nops = NOPS_W'(2);
            end
            8'h61: begin
                kind = K_WAIT_ARG;
                nops = NOPS_W'(2);
            end
            8'h62: begin
                kind     = K_WAIT_FIX;
                fix_wait = HOLD_SIXTIETH;
            end
            8'h63: begin
                kind     = K_WAIT_FIX;
                fix_wait = HOLD_FIFTIETH;
            end
            8'h66: kind = K_END;
            8'h67: begin
                kind = K_BLOCK;
                nops = NOPS_W'(6);
            end
            [8'h70:8'h7f]: begin
                kind     = K_WAIT_FIX;
                fix_wait = WAIT_W'(op[3:0]) + WAIT_W'(1);
            end
            [8'h80:8'h8f]: begin
                kind     = K_BANK;
                fix_wait = WAIT_W'(op[3:0]);
            end
            [8'ha0:8'haf], [8'hb1:8'hbf]: begin
                kind = K_SKIP;
                nops = NOPS_W'(2);
            end
            8'hc0, 8'hc1, 8'hd0, 8'hd1: begin
                kind = K_WRITE;
                nops = NOPS_W'(3);
            end
            [8'hc2:8'hcf], [8'hd2:8'hdf]: begin
                kind = K_SKIP;
                nops = NOPS_W'(3);
            end
            8'he0: begin
                kind = K_SEEK;
                nops = NOPS_W'(4);
            end
            [8'he1:8'hff]: begin
                kind = K_SKIP;
                nops = NOPS_W'(4);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/slog_operand_buf.sv
module slog_operand_buf #(
    parameter int NUM = 6,
    parameter int W   = 8,
    localparam int IDX_W = $clog2(NUM + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  capture,
    input  logic [W-1:0]          din,
    output logic [NUM-1:0][W-1:0] slots,
    output logic [IDX_W-1:0]      idx
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (capture) begin
            idx <= idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slots <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (capture && idx == IDX_W'(i)) begin
                    slots[i] <= din;
                end
            end
        end
    end

endmodule

// File: rtl/slog_downcnt.sv
module slog_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         at_one
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign at_one = (cnt == W'(1));

endmodule

// File: rtl/slog_decoder.sv
module slog_decoder
    import slog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              tick,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_target,
    output logic [BYTE_W-1:0] wr_port,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              seek_valid,
    output logic [SEEK_W-1:0] seek_offset,
    output logic              done
);

    dec_state_e st_q, st_d;

    op_kind_e          cls_kind, kind_q;
    logic [NOPS_W-1:0] cls_nops, nops_q;
    logic [WAIT_W-1:0] cls_fixw, fixw_q;
    logic [BYTE_W-1:0] op_q;

    logic [MAX_OPS-1:0][BYTE_W-1:0] ops;
    logic [NOPS_W-1:0]              op_idx;

    logic              accept, opc_take, opr_take, last_opr;
    logic [WAIT_W-1:0] exec_wait, wait_cnt;
    logic [LEN_W-1:0]  blk_size, blk_cnt;
    logic              wait_last, blk_last;

    assign accept   = in_valid && in_ready;
    assign opc_take = accept && (st_q == IDLE_OP);
    assign opr_take = accept && (st_q == GATHER);
    assign last_opr = opr_take && (op_idx == nops_q - NOPS_W'(1));

    slog_op_classify i_classify (
        .op       (in_data),
        .kind     (cls_kind),
        .nops     (cls_nops),
        .fix_wait (cls_fixw)
    );

    slog_operand_buf #(
        .NUM (MAX_OPS),
        .W   (BYTE_W)
    ) i_operands (
        .clk     (clk),
        .rst     (rst),
        .clear   (opc_take),
        .capture (opr_take),
        .din     (in_data),
        .slots   (ops),
        .idx     (op_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            kind_q <= K_IGNORE;
            nops_q <= '0;
            fixw_q <= '0;
        end else if (opc_take) begin
            op_q   <= in_data;
            kind_q <= cls_kind;
            nops_q <= cls_nops;
            fixw_q <= cls_fixw;
        end
    end

    always_comb begin
        exec_wait = '0;
        unique case (kind_q)
            K_WAIT_ARG:        exec_wait = {ops[1], ops[0]};
            K_WAIT_FIX, K_BANK: exec_wait = fixw_q;
            default: ;
        endcase
    end

    assign blk_size = (kind_q == K_BLOCK) ? {ops[5], ops[4], ops[3], ops[2]} : '0;

    slog_downcnt #(.W(WAIT_W)) i_hold_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (st_q == ISSUE),
        .load_val (exec_wait),
        .dec      ((st_q == HOLD) && tick),
        .cnt      (wait_cnt),
        .at_one   (wait_last)
    );

    slog_downcnt #(.W(LEN_W)) i_drain_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (st_q == ISSUE),
        .load_val (blk_size),
        .dec      (accept && (st_q == DRAIN)),
        .cnt      (blk_cnt),
        .at_one   (blk_last)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IDLE_OP: begin
                if (accept) begin
                    st_d = (cls_nops != '0) ? GATHER : ISSUE;
                end
            end
            GATHER: begin
                if (last_opr) begin
                    st_d = ISSUE;
                end
            end
            ISSUE: begin
                if (kind_q == K_END) begin
                    st_d = HALT;
                end else if (exec_wait != '0) begin
                    st_d = HOLD;
                end else if (blk_size != '0) begin
                    st_d = DRAIN;
                end else begin
                    st_d = IDLE_OP;
                end
            end
            HOLD: begin
                if (tick && wait_last) begin
                    st_d = IDLE_OP;
                end
            end
            DRAIN: begin
                if (accept && blk_last) begin
                    st_d = IDLE_OP;
                end
            end
            HALT: st_d = HALT;
            default: st_d = IDLE_OP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= IDLE_OP;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_ready    = (st_q == IDLE_OP) || (st_q == GATHER) || (st_q == DRAIN);
        done        = (st_q == HALT);
        wr_valid    = 1'b0;
        wr_target   = '0;
        wr_port     = '0;
        wr_addr     = '0;
        wr_data     = '0;
        seek_valid  = 1'b0;
        seek_offset = '0;
        if (st_q == ISSUE) begin
            unique case (kind_q)
                K_BANK: begin
                    wr_valid  = 1'b1;
                    wr_target = op_q;
                end
                K_WRITE: begin
                    wr_valid  = 1'b1;
                    wr_target = op_q;
                    if (nops_q == NOPS_W'(1)) begin
                        wr_data = ops[0];
                    end else if (nops_q == NOPS_W'(2)) begin
                        wr_addr = ADDR_W'(ops[0]);
                        wr_data = ops[1];
                    end else if (op_q[4]) begin
                        wr_port = ops[0];
                        wr_addr = ADDR_W'(ops[1]);
                        wr_data = ops[2];
                    end else begin
                        wr_addr = {ops[1], ops[0]};
                        wr_data = ops[2];
                    end
                end
                K_SEEK: begin
                    seek_valid  = 1'b1;
                    seek_offset = {ops[3], ops[2], ops[1], ops[0]};
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/slog_decoder_chk.sv
module slog_decoder_chk
    import slog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              tick,
    input logic              wr_valid,
    input logic              seek_valid,
    input logic              done,
    input logic [WAIT_W-1:0] wait_left,
    input logic [LEN_W-1:0]  blk_left
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !done && !wr_valid && !seek_valid));

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R5
    strobe_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !in_ready);

    // R10
    seek_alone_chk: assert property (@(posedge clk) disable iff (rst)
        seek_valid |-> !wr_valid);

    // R13
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R13
    done_closed_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!in_ready && !wr_valid && !seek_valid));

    // R9
    hold_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_left != '0) |-> !in_ready);

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_left != '0 && !tick) |=> (wait_left == $past(wait_left)));

    // R9
    hold_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_left != '0 && tick) |=> (wait_left == $past(wait_left) - WAIT_W'(1)));

    // R11
    drain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_left != '0) |-> (!wr_valid && !seek_valid && in_ready));

    // R11
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_left != '0 && in_valid && in_ready) |=> (blk_left == $past(blk_left) - LEN_W'(1)));

endmodule

bind slog_decoder slog_decoder_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .tick       (tick),
    .wr_valid   (wr_valid),
    .seek_valid (seek_valid),
    .done       (done),
    .wait_left  (wait_cnt),
    .blk_left   (blk_cnt)
);

// File: tb/test_slog_decoder.sv
module test_slog_decoder;
    import slog_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              tick = 1'b0;
    logic              wr_valid;
    logic [7:0]        wr_target, wr_port, wr_data;
    logic [15:0]       wr_addr;
    logic              seek_valid;
    logic [31:0]       seek_offset;
    logic              done;

    typedef struct packed {
        logic        seek;
        logic [7:0]  tgt;
        logic [7:0]  port;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [31:0] off;
    } ev_t;

    ev_t   exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slog_decoder i_slog_decoder (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .tick        (tick),
        .wr_valid    (wr_valid),
        .wr_target   (wr_target),
        .wr_port     (wr_port),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .seek_valid  (seek_valid),
        .seek_offset (seek_offset),
        .done        (done)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [7:0] t, input logic [7:0] p,
                             input logic [15:0] a, input logic [7:0] d, input string tag);
        exp_q.push_back('{seek: 1'b0, tgt: t, port: p, addr: a, data: d, off: 32'h0});
        tag_q.push_back(tag);
    endtask

    task automatic expect_seek(input logic [31:0] o, input string tag);
        exp_q.push_back('{seek: 1'b1, tgt: 8'h0, port: 8'h0, addr: 16'h0, data: 8'h0, off: o});
        tag_q.push_back(tag);
    endtask

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic hold_run(input int n, input string tag);
        repeat (3) @(negedge clk);
        for (int k = 1; k <= n; k++) begin
            if (k == n) check(in_ready == 1'b0, {tag, " held before last tick"}, 96'(in_ready), 96'(0));
            pulse_tick();
        end
        check(in_ready == 1'b1, {tag, " released after count"}, 96'(in_ready), 96'(1));
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && (wr_valid || seek_valid)) begin
            ev_t act;
            act = seek_valid ? '{seek: 1'b1, tgt: 8'h0, port: 8'h0, addr: 16'h0, data: 8'h0, off: seek_offset}
                             : '{seek: 1'b0, tgt: wr_target, port: wr_port, addr: wr_addr, data: wr_data, off: 32'h0};
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected strobe (R5/R11/R12/R14)", 96'(act), 96'(0));
            end else begin
                ev_t   e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, 96'(act), 96'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", 96'(in_ready), 96'(1));
        check(done == 1'b0, "R1 done after reset", 96'(done), 96'(0));
        check(!wr_valid && !seek_valid, "R1 strobes low after reset", 96'({wr_valid, seek_valid}), 96'(0));

        // R2 single-operand writes
        expect_wr(8'h50, 8'h0, 16'h0, 8'h9a, "R2 write 0x50");
        send_byte(8'h50); send_byte(8'h9a);
        expect_wr(8'h4f, 8'h0, 16'h0, 8'h33, "R2 write 0x4f");
        send_byte(8'h4f); send_byte(8'h33);

        // R3 address + data
        expect_wr(8'h52, 8'h0, 16'h0028, 8'hf0, "R3 write 0x52");
        send_byte(8'h52); send_byte(8'h28); send_byte(8'hf0);
        expect_wr(8'h5f, 8'h0, 16'h0001, 8'h02, "R3 write 0x5f");
        send_byte(8'h5f); send_byte(8'h01); send_byte(8'h02);
        expect_wr(8'hb0, 8'h0, 16'h0010, 8'h7e, "R3 write 0xb0");
        send_byte(8'hb0); send_byte(8'h10); send_byte(8'h7e);

        // R4 wide address and port forms
        expect_wr(8'hc0, 8'h0, 16'h1234, 8'h55, "R4 write 0xc0");
        send_byte(8'hc0); send_byte(8'h34); send_byte(8'h12); send_byte(8'h55);
        expect_wr(8'hd1, 8'h02, 16'h0044, 8'h66, "R4 write 0xd1");
        send_byte(8'hd1); send_byte(8'h02); send_byte(8'h44); send_byte(8'h66);

        // R5 strobe width and timing
        expect_wr(8'h50, 8'h0, 16'h0, 8'h01, "R5 strobe fields");
        send_byte(8'h50); send_byte(8'h01);
        check(wr_valid == 1'b1, "R5 strobe in cycle after last operand", 96'(wr_valid), 96'(1));
        @(negedge clk);
        check(wr_valid == 1'b0, "R5 strobe lasts one cycle", 96'(wr_valid), 96'(0));

        // R14 no-effect opcodes, then realignment
        send_byte(8'h00); send_byte(8'h60); send_byte(8'h9f); send_byte(8'h2f); send_byte(8'h6a);
        expect_wr(8'h50, 8'h0, 16'h0, 8'hc3, "R14 write after ignored opcodes");
        send_byte(8'h50); send_byte(8'hc3);

        // R12 reserved ranges
        send_byte(8'h30); send_byte(8'h50);
        send_byte(8'h4e); send_byte(8'h51);
        send_byte(8'ha0); send_byte(8'h50); send_byte(8'h50);
        send_byte(8'hbf); send_byte(8'h50); send_byte(8'h50);
        send_byte(8'hc2); send_byte(8'h50); send_byte(8'h50); send_byte(8'h50);
        send_byte(8'hdf); send_byte(8'h50); send_byte(8'h50); send_byte(8'h50);
        send_byte(8'he1); send_byte(8'h50); send_byte(8'h50); send_byte(8'h50); send_byte(8'h50);
        send_byte(8'hff); send_byte(8'h50); send_byte(8'h50); send_byte(8'h50); send_byte(8'h50);
        expect_wr(8'h50, 8'h0, 16'h0, 8'h77, "R12 write after reserved skips");
        send_byte(8'h50); send_byte(8'h77);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R12 framing kept", 96'(exp_q.size()), 96'(0));

        // R10 seek
        expect_seek(32'h12345678, "R10 seek offset");
        send_byte(8'he0); send_byte(8'h78); send_byte(8'h56); send_byte(8'h34); send_byte(8'h12);

        // R11 data blocks
        send_byte(8'h67); send_byte(8'h66); send_byte(8'h00);
        send_byte(8'h03); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h50); send_byte(8'h51); send_byte(8'h52);
        expect_wr(8'h50, 8'h0, 16'h0, 8'h21, "R11 write after 3-byte block");
        send_byte(8'h50); send_byte(8'h21);
        send_byte(8'h67); send_byte(8'h66); send_byte(8'h86);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        expect_wr(8'h50, 8'h0, 16'h0, 8'h22, "R11 write after empty block");
        send_byte(8'h50); send_byte(8'h22);
        send_byte(8'h67); send_byte(8'h66); send_byte(8'hfe);
        send_byte(8'h05); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00);
        for (int i = 0; i < 261; i++) send_byte(8'h5f);
        expect_wr(8'h50, 8'h0, 16'h0, 8'h23, "R11 write after 261-byte block");
        send_byte(8'h50); send_byte(8'h23);

        // R6 / R9 argument waits
        send_byte(8'h61); send_byte(8'h05); send_byte(8'h01);
        hold_run(261, "R6 R9 wait 0x0105");
        send_byte(8'h61); send_byte(8'h00); send_byte(8'h00);
        hold_run(0, "R6 wait zero");
        send_byte(8'h61); send_byte(8'h03); send_byte(8'h00);
        hold_run(3, "R6 R9 wait 3");

        // R7 fixed waits
        send_byte(8'h62);
        hold_run(735, "R7 wait 735");
        send_byte(8'h63);
        hold_run(882, "R7 wait 882");
        send_byte(8'h70);
        hold_run(1, "R7 wait 0x70");
        send_byte(8'h7f);
        hold_run(16, "R7 wait 0x7f");

        // R8 bank write then n ticks
        expect_wr(8'h80, 8'h0, 16'h0, 8'h0, "R8 bank write 0x80");
        send_byte(8'h80);
        hold_run(0, "R8 wait 0x80");
        expect_wr(8'h8f, 8'h0, 16'h0, 8'h0, "R8 bank write 0x8f");
        send_byte(8'h8f);
        hold_run(15, "R8 wait 0x8f");

        // R13 end of stream
        send_byte(8'h66);
        @(negedge clk);
        check(done == 1'b1, "R13 done raised", 96'(done), 96'(1));
        in_valid = 1'b1;
        in_data  = 8'h50;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!in_ready && done, "R13 input closed after end", 96'({in_ready, done}), 96'(1));
        end
        in_valid = 1'b0;

        // R1 reset clears end state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done == 1'b0 && in_ready == 1'b1, "R1 reset clears done", 96'({done, in_ready}), 96'(1));
        expect_wr(8'h50, 8'h0, 16'h0, 8'h44, "R1 first byte after reset is opcode");
        send_byte(8'h50); send_byte(8'h44);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 every expected strobe seen", 96'(exp_q.size()), 96'(0));
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule